// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

This block is a five-stage twisted-ring (Johnson) counter that divides its clock by any whole ratio from 2 to 10. The ratio is chosen on a select input, and an internal feedback selector picks the stage, or pair of stages, that feeds the first stage. The visible outputs are the inverse of the internal stage bits. A divided clock is taken from the lowest output. Its period is exactly N input clocks and it is high for ceil(N/2) of them.

Two asynchronous controls act without waiting for a clock edge. A clear input forces every output high. A preset input loads five parallel jam bits, and each output then shows the inverse of its jam bit. While either control is held, clock edges have no effect, and clear overrides preset. Gating inside the feedback selector detects stage patterns that lie off the counting sequence and returns the ring to it, so the counter can never stay trapped in a parasitic loop.

A chip-level active-low reset forces the same state as clear. Its release is synchronised to the clock.

Top module: `jdiv_counter`

## Requirements
- R1: While rst_n is low, q is 5'b11111 and clk_div is 1. After rst_n rises, the third rising clock edge is the first one that advances the counter.
- R2: A high level on clear drives q to 5'b11111 at once, with no clock edge. Clock edges while clear is held leave q at 5'b11111.
- R3: A high level on load, with clear low, makes q equal to ~jam at once, so q[i] = ~jam[i] for every bit. Clock edges while load is held leave q unchanged.
- R4: When clear and load are both high, q is 5'b11111 whatever jam holds.
- R5: On a rising edge with neither control asserted and the active window legal, q[i] takes the previous q[i-1] for i = 1..4.
- R6: For an even ratio N = 2k, the new q[0] is the inverse of the previous q[k-1].
- R7: For an odd ratio N = 2k-1 (k = 2..5), the new q[0] is the NAND of the previous q[k-2] and q[k-1].
- R8: clk_div equals q[0] and has a period of exactly N clocks, high for ceil(N/2) of them, for every N from 2 to 10.
- R9: A div_sel value of 0 or 1 acts as ratio 2, and a value above 10 acts as ratio 10.
- R10: The active window is q[k-1:0] with k = ceil(N/2). If that window holds more than one change between adjacent bits, the next rising edge sets q to 5'b11111, from which the legal sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert, synchronised release |
| clear | input | 1 | Asynchronous clear, active high, forces all outputs high |
| load | input | 1 | Asynchronous preset enable, active high |
| jam | input | 5 | Parallel preset data; output i shows ~jam[i] |
| div_sel | input | 4 | Divide ratio N; values below 2 clamp to 2, above 10 clamp to 10 |
| q | output | 5 | Stage outputs, inverse of the internal ring |
| clk_div | output | 1 | Divided clock, equal to q[0] |

## Verification
Clear and preset can be asserted together, and either one can be held across a rising clock edge. The bench raises load with a jam pattern, then raises clear on top of it. It expects all ones at once, then the jam inverse back when clear drops while load stays high. Both controls are held across edges, and the bench checks that the counter did not move. Illegal ring patterns are loaded through the preset. The bench then checks, at the first free edge, for the forced return to all ones, for the even and odd feedback rules, and for the measured output period at every ratio.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;

  // number of ring stages that take part in feedback for ratio n
  function automatic int ring_len(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/jdiv_rst_sync.sv
module jdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_ok
);

  logic meta_q;
  logic hold_q;
  logic meta_d;
  logic hold_d;

  always_comb begin
    meta_d = 1'b1;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign run_ok = hold_q;

endmodule

// File: rtl/jdiv_stage.sv
module jdiv_stage (
  input  logic clk,
  input  logic clr_a,
  input  logic set_a,
  input  logic en,
  input  logic d,
  output logic s
);

  // one ring bit with independent asynchronous clear and set
  always_ff @(posedge clk or posedge clr_a or posedge set_a) begin
    if (clr_a) begin
      s <= 1'b0;
    end else if (set_a) begin
      s <= 1'b1;
    end else if (en) begin
      s <= d;
    end
  end

endmodule

// File: rtl/jdiv_feedback.sv
module jdiv_feedback
  import jdiv_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic [STAGES-1:0] s,
  input  logic [SEL_W-1:0]  div_sel,
  output logic              d_fb,
  output logic              fix
);

  localparam int MIN_DIV = 2;
  localparam int MAX_DIV = 2 * STAGES;

  int      ratio;
  int      k;
  int      edges;
  parity_e par;
  logic    top_bit;
  logic    nxt_bit;

  always_comb begin
    ratio = int'(div_sel);
    if (ratio < MIN_DIV) ratio = MIN_DIV;
    if (ratio > MAX_DIV) ratio = MAX_DIV;
    k   = ring_len(ratio);
    par = (ratio % 2 == 1) ? PAR_ODD : PAR_EVEN;

    top_bit = 1'b0;
    nxt_bit = 1'b0;
    for (int j = 0; j < STAGES; j++) begin
      if (j == k - 1) top_bit = s[j];
      if (j == k - 2) nxt_bit = s[j];
    end

    // anti-lock: a legal window changes value at most once along its length
    edges = 0;
    for (int j = 0; j < STAGES - 1; j++) begin
      if ((j + 1 < k) && (s[j] != s[j+1])) edges = edges + 1;
    end
    fix = (edges > 1);

    if (par == PAR_ODD) d_fb = ~top_bit & ~nxt_bit;
    else                d_fb = ~top_bit;
  end

endmodule

// File: rtl/jdiv_counter.sv
module jdiv_counter #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [STAGES-1:0] jam,
  input  logic [SEL_W-1:0]  div_sel,
  output logic [STAGES-1:0] q,
  output logic              clk_div
);

  logic              rst_ok;
  logic              adv;
  logic              d_fb;
  logic              fix;
  logic [STAGES-1:0] s;
  logic [STAGES-1:0] s_nxt;
  logic [STAGES-1:0] clr_a;
  logic [STAGES-1:0] set_a;

  jdiv_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_ok (rst_ok)
  );

  jdiv_feedback #(
    .STAGES (STAGES),
    .SEL_W  (SEL_W)
  ) u_fb (
    .s       (s),
    .div_sel (div_sel),
    .d_fb    (d_fb),
    .fix     (fix)
  );

  assign adv = rst_ok & ~clear & ~load;

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      if (fix)         s_nxt[i] = 1'b0;
      else if (i == 0) s_nxt[i] = d_fb;
      else             s_nxt[i] = s[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign clr_a[g] = ~rst_ok | clear | (load & ~jam[g]);
    assign set_a[g] = rst_ok & ~clear & load & jam[g];

    jdiv_stage u_stage (
      .clk   (clk),
      .clr_a (clr_a[g]),
      .set_a (set_a[g]),
      .en    (adv),
      .d     (s_nxt[g]),
      .s     (s[g])
    );
  end

  assign q       = ~s;
  assign clk_div = q[0];

endmodule

// File: rtl/jdiv_counter_chk.sv
module jdiv_counter_chk #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              load,
  input logic [STAGES-1:0] jam,
  input logic [SEL_W-1:0]  div_sel,
  input logic [STAGES-1:0] q,
  input logic              run_ok
);

  int   n_eff;
  int   k_eff;
  int   chg;
  logic bad_win;
  logic exp_q0;

  always_comb begin
    n_eff = int'(div_sel);
    if (n_eff < 2) n_eff = 2;
    if (n_eff > 2 * STAGES) n_eff = 2 * STAGES;
    k_eff = (n_eff + 1) / 2;
    chg = 0;
    exp_q0 = 1'b0;
    for (int j = 0; j < STAGES - 1; j++) begin
      if ((j + 1 < k_eff) && (q[j] != q[j+1])) chg = chg + 1;
    end
    bad_win = (chg > 1);
    for (int j = 0; j < STAGES; j++) begin
      if (j == k_eff - 1) begin
        if (n_eff % 2 == 0) exp_q0 = ~q[j];
        else                exp_q0 = ~(q[j] & q[j-1 < 0 ? 0 : j-1]);
      end
    end
  end

  // R1
  a_r1_reset_ones: assert property (@(negedge clk) !rst_n |-> (q == '1));

  // R2
  a_r2_clear_ones: assert property (@(negedge clk) disable iff (!rst_n)
    clear |-> (q == '1));

  // R3
  a_r3_load_inverse: assert property (@(negedge clk) disable iff (!rst_n)
    (load && !clear && run_ok) |-> (q == ~jam));

  // R4
  a_r4_clear_wins: assert property (@(negedge clk) disable iff (!rst_n)
    (load && clear) |-> (q == '1));

  // R5
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n || clear || load)
    (run_ok && $past(run_ok) && !$past(clear) && !$past(load) && !$past(bad_win))
    |-> (q[STAGES-1:1] == $past(q[STAGES-2:0])));

  // R6, R7
  a_r6_r7_feedback: assert property (@(posedge clk) disable iff (!rst_n || clear || load)
    (run_ok && $past(run_ok) && !$past(clear) && !$past(load) && !$past(bad_win))
    |-> (q[0] == $past(exp_q0)));

  // R10
  a_r10_antilock: assert property (@(posedge clk) disable iff (!rst_n || clear || load)
    (run_ok && $past(run_ok) && !$past(clear) && !$past(load) && $past(bad_win))
    |-> (q == '1));

endmodule

bind jdiv_counter jdiv_counter_chk #(
  .STAGES (STAGES),
  .SEL_W  (SEL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear   (clear),
  .load    (load),
  .jam     (jam),
  .div_sel (div_sel),
  .q       (q),
  .run_ok  (rst_ok)
);

// File: tb/jdiv_counter_tb.sv
module jdiv_counter_tb;

  localparam int STAGES = 5;
  localparam int SEL_W  = 4;
  localparam int NV     = 12;

  // ratio select, expected period, expected high time
  localparam int V_SEL [NV] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 0, 1, 15};
  localparam int V_PER [NV] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 2, 2, 10};
  localparam int V_HI  [NV] = '{1, 2, 2, 3, 3, 4, 4, 5, 5, 1, 1, 5};

  logic              clk;
  logic              rst_n;
  logic              clear;
  logic              load;
  logic [STAGES-1:0] jam;
  logic [SEL_W-1:0]  div_sel;
  logic [STAGES-1:0] q;
  logic              clk_div;

  int total;
  int bad;
  bit done;

  jdiv_counter #(.STAGES(STAGES), .SEL_W(SEL_W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .load    (load),
    .jam     (jam),
    .div_sel (div_sel),
    .q       (q),
    .clk_div (clk_div)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next outputs from previous outputs, per R5, R6, R7, R9, R10
  function automatic logic [STAGES-1:0] model(input logic [STAGES-1:0] qp,
                                              input logic [SEL_W-1:0] sel);
    int n;
    int k;
    int ch;
    logic [STAGES-1:0] r;
    n = int'(sel);
    if (n < 2) n = 2;
    if (n > 10) n = 10;
    k = (n + 1) / 2;
    ch = 0;
    for (int j = 0; j + 1 < k; j++) if (qp[j] != qp[j+1]) ch++;
    if (ch > 1) return '1;
    r[STAGES-1:1] = qp[STAGES-2:0];
    if (n % 2 == 0) r[0] = ~qp[k-1];
    else            r[0] = ~(qp[k-2] & qp[k-1]);
    return r;
  endfunction

  task automatic drive_slot();
    @(negedge clk);
    #1;
  endtask

  task automatic step_model(input string req, input int edges);
    for (int e = 0; e < edges; e++) begin
      logic [STAGES-1:0] expq;
      expq = model(q, div_sel);
      @(posedge clk);
      @(negedge clk);
      chk(req, int'(q), int'(expq));
      #1;
    end
  endtask

  task automatic preset(input logic [STAGES-1:0] v);
    drive_slot();
    jam  = v;
    load = 1'b1;
    drive_slot();
    load = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad = 0;
    done = 0;
    rst_n = 1'b0;
    clear = 1'b0;
    load = 1'b0;
    jam = '0;
    div_sel = 4'd10;
    repeat (4) @(negedge clk);
    chk("R1 reset q", int'(q), 'h1f);
    chk("R1 reset clk_div", int'(clk_div), 1);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 held during sync", int'(q), 'h1f);
    @(negedge clk);
    chk("R1 third edge advances", int'(q), 'h1e);

    // table walk: period and high time of clk_div for each ratio (R8, R9)
    for (int v = 0; v < NV; v++) begin
      int smp [40];
      int r1;
      int r2;
      int hi;
      drive_slot();
      div_sel = SEL_W'(V_SEL[v]);
      clear = 1'b1;
      drive_slot();
      clear = 1'b0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        smp[c] = int'(clk_div);
      end
      r1 = -1;
      r2 = -1;
      for (int c = 1; c < 40; c++) begin
        if (smp[c] == 1 && smp[c-1] == 0) begin
          if (r1 < 0) r1 = c;
          else if (r2 < 0) r2 = c;
        end
      end
      hi = 0;
      if (r1 >= 0 && r2 > r1) for (int c = r1; c < r2; c++) hi += smp[c];
      if (V_SEL[v] < 2 || V_SEL[v] > 10) begin
        chk("R9 clamped period", r2 - r1, V_PER[v]);
        chk("R9 clamped high", hi, V_HI[v]);
      end else begin
        chk("R8 period", r2 - r1, V_PER[v]);
        chk("R8 high time", hi, V_HI[v]);
      end
    end

    // R3: asynchronous preset, edges ignored while held
    drive_slot();
    div_sel = 4'd10;
    jam = 5'b10110;
    load = 1'b1;
    #1;
    chk("R3 async load", int'(q), 'h09);
    repeat (2) @(negedge clk);
    chk("R3 edges ignored", int'(q), 'h09);

    // R4: clear on top of load, then load alone again
    #1;
    clear = 1'b1;
    #1;
    chk("R4 clear wins", int'(q), 'h1f);
    @(negedge clk);
    chk("R4 clear wins over edge", int'(q), 'h1f);
    #1;
    clear = 1'b0;
    #1;
    chk("R3 load after clear", int'(q), 'h09);
    load = 1'b0;

    // R2: asynchronous clear alone, held across edges
    drive_slot();
    clear = 1'b1;
    #1;
    chk("R2 async clear", int'(q), 'h1f);
    repeat (2) @(negedge clk);
    chk("R2 edges ignored", int'(q), 'h1f);
    #1;
    clear = 1'b0;

    // R5, R6: even ratios from a legal preset
    preset(5'b00011);
    step_model("R5 R6 even N=10", 12);
    drive_slot();
    div_sel = 4'd6;
    preset(5'b00001);
    step_model("R6 even N=6", 8);

    // R7: odd ratios
    drive_slot();
    div_sel = 4'd7;
    preset(5'b00000);
    step_model("R7 odd N=7", 10);
    drive_slot();
    div_sel = 4'd3;
    preset(5'b00000);
    step_model("R7 odd N=3", 6);

    // R10: illegal windows return to all ones
    drive_slot();
    div_sel = 4'd6;
    preset(5'b00010);
    @(posedge clk);
    @(negedge clk);
    chk("R10 recover N=6", int'(q), 'h1f);
    #1;
    step_model("R10 sequence after recovery N=6", 6);
    drive_slot();
    div_sel = 4'd10;
    preset(5'b01010);
    @(posedge clk);
    @(negedge clk);
    chk("R10 recover N=10", int'(q), 'h1f);
    #1;
    drive_slot();
    div_sel = 4'd9;
    preset(5'b10101);
    @(posedge clk);
    @(negedge clk);
    chk("R10 recover N=9", int'(q), 'h1f);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule